// File: doc/BRIEF.md
# Auto Stop-Command Response Checker

When a multi-block memory transfer ends, the host sends a stop command by itself. This block watches the command line after that command has gone out. It waits for the card's reply, collects the 48-bit response one bit per SD clock and judges the response. The result is kept in an 8-bit error status word. The controller reads this word to decide whether the transfer closed cleanly.

The status word also records two other events. One is that the stop command could never be sent because an earlier error occurred. The other is that a later plain command, one without data, was held back because the stop command failed.

The command line enters as a pre-sampled bit, qualified by a one-cycle SD-clock-enable strobe. There is no stream handshake at the block's edge and no back-pressure: the card drives the line at its own pace, so every strobe cycle must be accepted. All control inputs are single-cycle pulses, apart from `xfer_active`, which is a level. All outputs are plain registers.

Top module: `ac12_resp_chk`

## Requirements
- R1: A `stop_issued` pulse clears the whole status word to 0x00 and raises `busy` on the next cycle. It restarts any check already in progress.
- R2: After `stop_issued`, the check times out if 64 strobes pass with `cmd_in` high. The status then becomes exactly 0x02 (bit 1). A start bit (0) that arrives on the 64th strobe is still accepted as a response.
- R3: `cmd_in` is sampled only in cycles where `sd_tick` is high. Its value in all other cycles has no effect.
- R4: The response is sent MSB first: a start bit (0), a transmission bit, a 6-bit command index, a 32-bit argument, a 7-bit CRC and an end bit. Status bit 4 is set when the index is not 12.
- R5: The CRC is computed with polynomial x^7+x^3+1 (feedback mask 0x09), starting from zero, over response bits 0 to 39. Status bit 3 is set when this value differs from the CRC carried in bits 40 to 46.
- R6: Status bit 2 is set when response bit 47, the end bit, is 0.
- R7: `done` is high for exactly one cycle. It rises on the same edge that writes the result into the status word, either on the last response bit or on the timeout. `busy` is low while `done` is high.
- R8: A `stop_fail` pulse while idle with `xfer_active` high sets the status word to exactly 0x01, so bits 1 to 4 are zero.
- R9: A `stop_fail` pulse with `xfer_active` low leaves the status word unchanged.
- R10: A `plain_blocked` pulse sets status bit 7 when any of bits 0 to 4 is set at that moment. Otherwise it has no effect.
- R11: Status bits 6 and 5 always read 0. Whenever bit 1 (timeout) is set, bits 2 to 4 are 0.
- R12: An `abort` pulse while busy returns the block to idle. No `done` pulse follows, and the status word is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_tick | input | 1 | SD-clock enable strobe; qualifies `cmd_in` |
| cmd_in | input | 1 | Sampled command-line level |
| stop_issued | input | 1 | Pulse at the end bit of the sent stop command |
| stop_fail | input | 1 | Pulse: the stop command could not be sent |
| xfer_active | input | 1 | Level: the multi-block transfer had started |
| plain_blocked | input | 1 | Pulse: a later data-less command was held back |
| abort | input | 1 | Pulse: abandon the current check |
| busy | output | 1 | Waiting for or receiving the response |
| done | output | 1 | One-cycle pulse when the check finishes |
| status | output | 8 | Error status word (bit 0 not sent, 1 timeout, 2 end bit, 3 CRC, 4 index, 7 plain command held) |

## Verification
On every cycle, the assertions check the following: the reserved bits stay at zero, the masking rules for the timeout and not-sent flags hold, `done` is a single-cycle pulse that never overlaps `busy`, `stop_issued` clears the status and `abort` ends a check silently. They also keep the wait counter and the bit counter inside their bounds. Only the bench scenarios can show that a given response yields the correct index, CRC and end-bit verdict, that the timeout falls on exactly the 64th idle strobe, and that level changes between strobes are ignored. For these, a behavioural model rebuilds the frame, and its outputs are compared with the block's outputs on every clock.

// File: rtl/ac12_pkg.sv
package ac12_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_WAIT = 2'd1,
    RX_RECV = 2'd2
  } rx_state_e;

  // Status word bit positions (software decodes these)
  localparam int STS_NE  = 0;
  localparam int STS_TMO = 1;
  localparam int STS_END = 2;
  localparam int STS_CRC = 3;
  localparam int STS_IDX = 4;
  localparam int STS_BLK = 7;

endpackage

// File: rtl/ac12_crc7.sv
module ac12_crc7 #(
  parameter int             W    = 7,
  parameter logic [W-1:0]   POLY = 7'h09
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);

  logic fb;
  assign fb = din ^ crc[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= {crc[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
  end

endmodule

// File: rtl/ac12_frame_rx.sv
module ac12_frame_rx
  import ac12_pkg::*;
#(
  parameter int RESP_BITS = 48,
  parameter int TMO_TICKS = 64,
  parameter int CRC_SPAN  = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   cmd_in,
  input  logic                   go,
  input  logic                   abort,
  output logic                   busy,
  output logic                   tmo_evt,
  output logic                   frame_evt,
  output logic                   crc_en,
  output logic [RESP_BITS-4:0]   hold
);

  localparam int BW = $clog2(RESP_BITS + 1);
  localparam int TW = $clog2(TMO_TICKS + 1);
  localparam int HW = RESP_BITS - 3;

  rx_state_e         state;
  logic [BW-1:0]     bcnt;
  logic [TW-1:0]     wcnt;

  assign busy = (state != RX_IDLE);

  always_comb begin
    crc_en    = 1'b0;
    tmo_evt   = 1'b0;
    frame_evt = 1'b0;
    if (!go && !abort && tick) begin
      case (state)
        RX_WAIT: begin
          if (!cmd_in)                            crc_en  = 1'b1;
          else if (wcnt == TW'(TMO_TICKS - 1))    tmo_evt = 1'b1;
        end
        RX_RECV: begin
          if (bcnt < BW'(CRC_SPAN))               crc_en    = 1'b1;
          if (bcnt == BW'(RESP_BITS - 1))         frame_evt = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      bcnt  <= '0;
      wcnt  <= '0;
      hold  <= '0;
    end else if (go) begin
      state <= RX_WAIT;
      bcnt  <= '0;
      wcnt  <= '0;
    end else if (abort) begin
      state <= RX_IDLE;
    end else if (tick) begin
      case (state)
        RX_WAIT: begin
          if (!cmd_in) begin
            hold  <= {hold[HW-2:0], cmd_in};
            bcnt  <= BW'(1);
            state <= RX_RECV;
          end else if (tmo_evt) begin
            state <= RX_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        RX_RECV: begin
          if (frame_evt) begin
            state <= RX_IDLE;
          end else begin
            hold <= {hold[HW-2:0], cmd_in};
            bcnt <= bcnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  p_wait_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_WAIT) |-> (wcnt < TW'(TMO_TICKS)));

  p_frame_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_RECV) |-> (bcnt < BW'(RESP_BITS)));

endmodule

// File: rtl/ac12_resp_chk.sv
module ac12_resp_chk
  import ac12_pkg::*;
#(
  parameter int RESP_BITS  = 48,
  parameter int TMO_TICKS  = 64,
  parameter int CRC_W      = 7,
  parameter int IDX_W      = 6,
  parameter int IDX_EXPECT = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sd_tick,
  input  logic       cmd_in,
  input  logic       stop_issued,
  input  logic       stop_fail,
  input  logic       xfer_active,
  input  logic       plain_blocked,
  input  logic       abort,
  output logic       busy,
  output logic       done,
  output logic [7:0] status
);

  localparam int CRC_SPAN = RESP_BITS - CRC_W - 1;
  localparam int HW       = RESP_BITS - 3;
  localparam int IDX_HI   = HW - 1;

  logic             tmo_evt, frame_evt, crc_en;
  logic [HW-1:0]    hold;
  logic [CRC_W-1:0] crc_calc;
  logic             idx_err, crc_err, end_err;
  logic [7:0]       status_nxt;

  ac12_frame_rx #(
    .RESP_BITS (RESP_BITS),
    .TMO_TICKS (TMO_TICKS),
    .CRC_SPAN  (CRC_SPAN)
  ) rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sd_tick),
    .cmd_in    (cmd_in),
    .go        (stop_issued),
    .abort     (abort),
    .busy      (busy),
    .tmo_evt   (tmo_evt),
    .frame_evt (frame_evt),
    .crc_en    (crc_en),
    .hold      (hold)
  );

  ac12_crc7 #(
    .W    (CRC_W),
    .POLY (CRC_W'(7'h09))
  ) crc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stop_issued),
    .en    (crc_en),
    .din   (cmd_in),
    .crc   (crc_calc)
  );

  // Verdicts, valid in the cycle the end bit is on the line
  assign idx_err = (hold[IDX_HI -: IDX_W] != IDX_W'(IDX_EXPECT));
  assign crc_err = (hold[CRC_W-1:0] != crc_calc);
  assign end_err = !cmd_in;

  always_comb begin
    status_nxt = status;
    if (tmo_evt) begin
      status_nxt          = '0;
      status_nxt[STS_TMO] = 1'b1;
    end else if (frame_evt) begin
      status_nxt          = '0;
      status_nxt[STS_IDX] = idx_err;
      status_nxt[STS_CRC] = crc_err;
      status_nxt[STS_END] = end_err;
    end else if (!busy && stop_fail && xfer_active) begin
      status_nxt         = '0;
      status_nxt[STS_NE] = 1'b1;
    end
    if (plain_blocked && (status[4:0] != 5'd0))
      status_nxt[STS_BLK] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      done   <= 1'b0;
    end else if (stop_issued) begin
      status <= '0;
      done   <= 1'b0;
    end else begin
      status <= status_nxt;
      done   <= tmo_evt | frame_evt;
    end
  end

  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:5] == 2'b00);

  p_tmo_masks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status[STS_TMO] |-> (status[4:2] == 3'b000));

  p_ne_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status[STS_NE] |-> (status[4:1] == 4'b0000));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_clear_on_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_issued |=> (status == 8'h00) && busy);

  p_abort_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy && !stop_issued) |=> (!busy && !done && $stable(status)));

endmodule

// File: tb/ac12_resp_chk_tb_top.sv
module ac12_resp_chk_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cmd = 1'b1, issue = 1'b0, fail = 1'b0;
  logic       xfer = 1'b0, blk = 1'b0, abrt = 1'b0;
  logic       busy, done;
  logic [7:0] status;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #5 clk = ~clk;

  ac12_resp_chk dut_i (
    .clk(clk), .rst_n(rst_n), .sd_tick(tick), .cmd_in(cmd),
    .stop_issued(issue), .stop_fail(fail), .xfer_active(xfer),
    .plain_blocked(blk), .abort(abrt),
    .busy(busy), .done(done), .status(status)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_status;
  bit         m_busy, m_done;
  int         m_wait;
  bit         q[$];

  function automatic logic [6:0] crc_of(input logic [47:0] f);
    logic [6:0] c = '0;
    for (int i = 0; i < 40; i++) begin
      logic fb = f[47-i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [7:0] eval_q();
    logic [47:0] f = '0;
    logic [7:0]  s = '0;
    for (int i = 0; i < 48; i++) f[47-i] = q[i];
    if (f[45:40] != 6'd12)        s[4] = 1'b1;
    if (f[7:1] != crc_of(f))      s[3] = 1'b1;
    if (f[0] == 1'b0)             s[2] = 1'b1;
    return s;
  endfunction

  always @(posedge clk) begin
    logic [7:0] old_s;
    old_s = m_status;
    if (!rst_n) begin
      m_status = '0; m_busy = 0; m_done = 0; m_wait = 0; q.delete();
    end else begin
      m_done = 0;
      if (issue) begin
        m_status = '0; m_busy = 1; m_wait = 0; q.delete();
      end else begin
        if (m_busy && abrt) m_busy = 0;
        else if (m_busy && tick) begin
          if (q.size() == 0) begin
            if (cmd == 1'b0) q.push_back(1'b0);
            else begin
              m_wait++;
              if (m_wait == 64) begin m_status = 8'h02; m_done = 1; m_busy = 0; end
            end
          end else begin
            q.push_back(cmd);
            if (q.size() == 48) begin m_status = eval_q(); m_done = 1; m_busy = 0; end
          end
        end else if (!m_busy && fail && xfer) m_status = 8'h01;
        if (blk && old_s[4:0] != 5'd0) m_status[7] = 1'b1;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk({cur_req, " model-status"}, {24'd0, status}, {24'd0, m_status});
    chk({cur_req, " model-done"},   {31'd0, done},   {31'd0, m_done});
    chk({cur_req, " model-busy"},   {31'd0, busy},   {31'd0, m_busy});
  endtask

  task automatic do_issue();
    issue = 1; step(); issue = 0;
  endtask

  function automatic logic [47:0] mk(input logic [5:0] idx, input logic [31:0] arg,
                                     input bit crc_ok, input logic endb);
    logic [47:0] f = {1'b0, 1'b0, idx, arg, 7'd0, endb};
    f[7:1] = crc_of(f);
    if (!crc_ok) f[1] = ~f[1];
    return f;
  endfunction

  task automatic send(input logic [47:0] f, input int gap, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      tick = 1; cmd = f[47-i]; step(); tick = 0;
      if (i != nbits - 1)
        for (int g = 0; g < gap; g++) begin cmd = ~f[47-i]; step(); end
    end
    tick = 0; cmd = 1;
  endtask

  task automatic run_frame(input string req, input logic [5:0] idx, input logic [31:0] arg,
                           input bit crc_ok, input logic endb, input int gap,
                           input logic [7:0] exp);
    cur_req = req;
    do_issue();
    cmd = 0; step(); step(); cmd = 1;   // line low without strobe: ignored (R3)
    send(mk(idx, arg, crc_ok, endb), gap, 48);
    chk({req, " done"}, {31'd0, done}, 32'd1);
    chk({req, " status"}, {24'd0, status}, {24'd0, exp});
    step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", {24'd0, status}, 32'h0);
    chk("R7 reset done", {31'd0, done}, 32'h0);
    chk("R1 reset busy", {31'd0, busy}, 32'h0);

    // Clean response, then single and combined errors
    run_frame("R4 good", 6'd12, 32'h1234_5678, 1, 1, 0, 8'h00);
    run_frame("R4 index", 6'd13, 32'hCAFE_0001, 1, 1, 1, 8'h10);
    run_frame("R5 crc", 6'd12, 32'h0000_0000, 0, 1, 2, 8'h08);
    run_frame("R6 endbit", 6'd12, 32'hFFFF_FFFF, 1, 0, 1, 8'h04);
    run_frame("R5 all", 6'd0, 32'hA5A5_5A5A, 0, 0, 3, 8'h1C);

    // R3: idle strobes, then frame with inverted levels between strobes
    cur_req = "R3";
    do_issue();
    for (int i = 0; i < 10; i++) begin tick = 1; cmd = 1; step(); tick = 0; cmd = 0; step(); end
    cmd = 1;
    send(mk(6'd12, 32'h0F0F_F0F0, 1, 1), 2, 48);
    chk("R3 status", {24'd0, status}, 32'h00);
    chk("R3 done", {31'd0, done}, 32'd1);
    step();

    // R2 / R11: timeout exactly on the 64th idle strobe
    cur_req = "R2";
    do_issue();
    for (int i = 0; i < 63; i++) begin tick = 1; cmd = 1; step(); end
    chk("R2 not yet done", {31'd0, done}, 32'd0);
    chk("R2 still busy", {31'd0, busy}, 32'd1);
    step();
    chk("R2 timeout done", {31'd0, done}, 32'd1);
    chk("R11 timeout status", {24'd0, status}, 32'h02);
    tick = 0; step();
    chk("R7 done single", {31'd0, done}, 32'd0);

    // R10: blocked plain command after an error
    cur_req = "R10";
    blk = 1; step(); blk = 0;
    chk("R10 blocked set", {24'd0, status}, 32'h82);

    // R2 boundary: start bit on the 64th strobe
    cur_req = "R2";
    do_issue();
    for (int i = 0; i < 63; i++) begin tick = 1; cmd = 1; step(); end
    send(mk(6'd12, 32'h0000_0042, 1, 1), 0, 48);
    chk("R2 late start accepted", {24'd0, status}, 32'h00);
    chk("R2 late start done", {31'd0, done}, 32'd1);
    step();

    cur_req = "R10";
    blk = 1; step(); blk = 0;
    chk("R10 blocked no effect", {24'd0, status}, 32'h00);

    // R8: stop not sent while transfer active
    cur_req = "R8";
    xfer = 1; fail = 1; step(); fail = 0;
    chk("R8 not executed", {24'd0, status}, 32'h01);
    blk = 1; step(); blk = 0;
    chk("R10 blocked after ne", {24'd0, status}, 32'h81);

    // R1: new stop clears everything
    cur_req = "R1";
    do_issue();
    chk("R1 cleared", {24'd0, status}, 32'h00);
    chk("R1 busy", {31'd0, busy}, 32'd1);
    xfer = 0;

    // R12: abort mid-response
    cur_req = "R12";
    send(mk(6'd12, 32'h1111_2222, 1, 1), 0, 20);
    abrt = 1; step(); abrt = 0;
    chk("R12 idle", {31'd0, busy}, 32'd0);
    for (int i = 0; i < 40; i++) begin tick = 1; cmd = i[0]; step(); end
    tick = 0; cmd = 1;
    chk("R12 no done", {31'd0, done}, 32'd0);
    chk("R12 status kept", {24'd0, status}, 32'h00);

    // R9: stop failure with no transfer started leaves status alone
    run_frame("R9 setup", 6'd7, 32'h0, 1, 1, 0, 8'h10);
    cur_req = "R9";
    xfer = 0; fail = 1; step(); fail = 0;
    chk("R9 unchanged", {24'd0, status}, 32'h10);
    step(); step();

    finished = 1;
    summary();
    $finish;
  end

endmodule